// File: doc/BRIEF.md
# Reset Cause Recorder with Keyed Source Masking

This block sits beside the chip's reset distribution logic and decides which reset requests are allowed through, and it records which source caused the last one. Seven request inputs can arrive: watchdog, watchdog-3, temperature sensor, core lockup, software request, JTAG-generated reset and JTAG software reset. Each input is sampled on the clock. A qualified request raises a global reset request, or for watchdog-3 it can raise a core-only reset request instead. The power-on reset input `por_n` is the block's own hardware reset.

Software sees two words through a single-address-bit register port. The control word holds the watchdog and temperature-sensor masks, the core-lockup enable and the watchdog-3 routing option. Each mask is a 4-bit keyed code, so a single flipped bit cannot quietly mask a source. Only the exact mask code masks a source, and every other value leaves it active. The status word holds one write-one-to-clear flag for each cause and a plain read/write warm-boot flag. Software sets the warm-boot flag before it asks for a warm restart.

Top module: `reset_cause_rec`

## Requirements
- R1: While `por_n` is low and after it is released, the status word reads 0x001 (only the power-on flag at bit 0 is set, warm-boot clear). The control word reads 0x02A: watchdog key 0xA in bits [3:0], sensor key 0x2 in bits [7:4], lockup enable (bit 8) 0, watchdog-3 option (bit 9) 0. Both request outputs are low.
- R2: A qualified request that is high at a clock edge sets its own status flag and drives `glob_rst_req` high in the following cycle. Status flag positions: 1 watchdog, 2 temperature sensor, 3 core lockup, 4 software request, 5 JTAG-generated, 6 JTAG software, 7 watchdog-3. Software and both JTAG requests are always qualified. With no qualified request, `glob_rst_req` is low in the next cycle.
- R3: The watchdog key 0x5 masks the watchdog request, so no global request results. Key 0xA leaves it active.
- R4: A watchdog event still sets status bit 1 while the watchdog is masked. From then on, bit 1 ignores write-one-to-clear, even after the watchdog is unmasked, until `por_n` is asserted.
- R5: The sensor key 0x5 masks the temperature-sensor request, which then sets neither status bit 2 nor a global request. Key 0x2 leaves it active.
- R6: While `tsense_evt` is high, a write-one-to-clear of status bit 2 has no effect. Once the input is low, the write clears the bit.
- R7: Any key value other than 0x5 leaves its source active.
- R8: A core lockup event raises a global request and sets status bit 3 only when control bit 8 is 1.
- R9: A watchdog-3 event always sets status bit 7. It raises `core_rst_req` when control bit 9 is 0, and `glob_rst_req` when bit 9 is 1.
- R10: A write to the status word (address 1) clears each cause flag whose data bit in [7:0] is 1 and loads data bit 8 into the warm-boot flag. Cause flags whose data bit is 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdog_evt | input | 1 | Watchdog reset request |
| tsense_evt | input | 1 | Temperature-sensor interrupt (level) |
| lockup_evt | input | 1 | Core lockup indication |
| swreq_evt | input | 1 | Software reset request |
| jtag_gen_evt | input | 1 | JTAG-generated reset request |
| jtag_sw_evt | input | 1 | JTAG software reset request |
| wdog3_evt | input | 1 | Watchdog-3 reset request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the control word, 1 selects the status word |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data for the word that `addr` selects |
| glob_rst_req | output | 1 | Global reset request, registered |
| core_rst_req | output | 1 | Core-only reset request, registered |

## Verification
The bench looks for a watchdog event taken while masked, then unmasks the watchdog and tries to clear the flag. A design that ties stickiness to the current mask would lose the flag there. It tries to clear the sensor flag while the sensor input is still high, which catches a design that ignores the input's level. It writes unused key values such as 0x0 and 0xF, which a design that tests only one key bit would treat as masked. It also toggles warm-boot with cause bits at zero, so a read-modify-write that wipes the causes shows up. Lockup enable and watchdog-3 routing are checked on both settings, looking at both request outputs.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
   localparam int unsigned NUM_CAUSE   = 8;
   localparam int unsigned CB_POR      = 0;
   localparam int unsigned CB_WDOG     = 1;
   localparam int unsigned CB_TSENSE   = 2;
   localparam int unsigned CB_LOCKUP   = 3;
   localparam int unsigned CB_SWREQ    = 4;
   localparam int unsigned CB_JTAG_GEN = 5;
   localparam int unsigned CB_JTAG_SW  = 6;
   localparam int unsigned CB_WDOG3    = 7;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   // A key masks its source only on an exact match; anything else fails safe.
   function automatic logic key_masks(input logic [7:0] key, input logic [7:0] mask_code);
      return key == mask_code;
   endfunction
endpackage

// File: rtl/rcr_ctrl_regs.sv
module rcr_ctrl_regs #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned KEY_W   = 4,
   parameter logic [KEY_W-1:0] WD_RUN_KEY = 4'hA,
   parameter logic [KEY_W-1:0] TS_RUN_KEY = 4'h2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wr_data,
   output logic [KEY_W-1:0]  wd_key,
   output logic [KEY_W-1:0]  ts_key,
   output logic              lockup_en,
   output logic              wdog3_glob
);
   localparam int unsigned TS_LSB = KEY_W;
   localparam int unsigned LU_BIT = 2 * KEY_W;
   localparam int unsigned W3_BIT = 2 * KEY_W + 1;

   if (W3_BIT >= DATA_W) begin : g_bad_width
      $error("control fields do not fit in DATA_W");
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wd_key     <= WD_RUN_KEY;
         ts_key     <= TS_RUN_KEY;
         lockup_en  <= 1'b0;
         wdog3_glob <= 1'b0;
      end else if (wr_ctrl) begin
         wd_key     <= wr_data[KEY_W-1:0];
         ts_key     <= wr_data[TS_LSB +: KEY_W];
         lockup_en  <= wr_data[LU_BIT];
         wdog3_glob <= wr_data[W3_BIT];
      end
   end
endmodule

// File: rtl/rcr_qualify.sv
module rcr_qualify
   import rcr_pkg::*;
#(
   parameter int unsigned NCAUSE = NUM_CAUSE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wdog_evt,
   input  logic              tsense_evt,
   input  logic              lockup_evt,
   input  logic              swreq_evt,
   input  logic              jtag_gen_evt,
   input  logic              jtag_sw_evt,
   input  logic              wdog3_evt,
   input  logic              wd_masked,
   input  logic              ts_masked,
   input  logic              lockup_en,
   input  logic              wdog3_glob,
   output logic [NCAUSE-1:0] set_vec,
   output logic [NCAUSE-1:0] blk_vec,
   output logic              glob_rst_req,
   output logic              core_rst_req
);
   if (NCAUSE != NUM_CAUSE) begin : g_bad_count
      $error("cause count must match the package");
   end

   logic wd_lock_q;
   logic wd_go, ts_go, lu_go, glob_d, core_d;

   assign wd_go = wdog_evt & ~wd_masked;
   assign ts_go = tsense_evt & ~ts_masked;
   assign lu_go = lockup_evt & lockup_en;

   always_comb begin
      set_vec              = '0;
      set_vec[CB_WDOG]     = wdog_evt;
      set_vec[CB_TSENSE]   = ts_go;
      set_vec[CB_LOCKUP]   = lu_go;
      set_vec[CB_SWREQ]    = swreq_evt;
      set_vec[CB_JTAG_GEN] = jtag_gen_evt;
      set_vec[CB_JTAG_SW]  = jtag_sw_evt;
      set_vec[CB_WDOG3]    = wdog3_evt;
      blk_vec              = '0;
      blk_vec[CB_WDOG]     = wd_lock_q;
      blk_vec[CB_TSENSE]   = tsense_evt;
   end

   assign glob_d = wd_go | ts_go | lu_go | swreq_evt | jtag_gen_evt | jtag_sw_evt
                 | (wdog3_evt & wdog3_glob);
   assign core_d = wdog3_evt & ~wdog3_glob;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wd_lock_q    <= 1'b0;
         glob_rst_req <= 1'b0;
         core_rst_req <= 1'b0;
      end else begin
         wd_lock_q    <= wd_lock_q | (wdog_evt & wd_masked);
         glob_rst_req <= glob_d;
         core_rst_req <= core_d;
      end
   end

   AST_SW_GLOBAL: assert property (@(posedge clk) disable iff (!por_n)
      swreq_evt |=> glob_rst_req); // R2
   AST_WDOG_MASKED: assert property (@(posedge clk) disable iff (!por_n)
      (wdog_evt && wd_masked && !tsense_evt && !lockup_evt && !swreq_evt && !jtag_gen_evt
       && !jtag_sw_evt && !wdog3_evt) |=> !glob_rst_req); // R3
   AST_LOCKUP_GATED: assert property (@(posedge clk) disable iff (!por_n)
      (lockup_evt && !lockup_en && !wdog_evt && !tsense_evt && !swreq_evt && !jtag_gen_evt
       && !jtag_sw_evt && !wdog3_evt) |=> !glob_rst_req); // R8
   AST_W3_CORE: assert property (@(posedge clk) disable iff (!por_n)
      (wdog3_evt && !wdog3_glob) |=> core_rst_req); // R9
   AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!por_n)
      wd_lock_q |=> wd_lock_q); // R4
endmodule

// File: rtl/rcr_cause_flags.sv
module rcr_cause_flags
   import rcr_pkg::*;
#(
   parameter int unsigned NCAUSE = NUM_CAUSE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [NCAUSE-1:0] set_vec,
   input  logic [NCAUSE-1:0] blk_vec,
   input  logic [NCAUSE-1:0] w1c_vec,
   input  logic              wb_wr,
   input  logic              wb_data,
   output logic [NCAUSE-1:0] flags,
   output logic              warm_boot
);
   for (genvar i = 0; i < NCAUSE; i++) begin : g_flag
      localparam logic RST_VAL = (i == CB_POR);
      logic bit_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                       bit_q <= RST_VAL;
         else if (set_vec[i])              bit_q <= 1'b1;
         else if (w1c_vec[i] && !blk_vec[i]) bit_q <= 1'b0;
      end
      assign flags[i] = bit_q;

      AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!por_n)
         (bit_q && blk_vec[i]) |=> bit_q); // R6
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     warm_boot <= 1'b0;
      else if (wb_wr) warm_boot <= wb_data;
   end
endmodule

// File: rtl/reset_cause_rec.sv
module reset_cause_rec
   import rcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned KEY_W  = 4,
   parameter logic [KEY_W-1:0] WD_RUN_KEY = 4'hA,
   parameter logic [KEY_W-1:0] TS_RUN_KEY = 4'h2,
   parameter logic [KEY_W-1:0] MASK_KEY   = 4'h5
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wdog_evt,
   input  logic              tsense_evt,
   input  logic              lockup_evt,
   input  logic              swreq_evt,
   input  logic              jtag_gen_evt,
   input  logic              jtag_sw_evt,
   input  logic              wdog3_evt,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              glob_rst_req,
   output logic              core_rst_req
);
   localparam int unsigned WB_BIT  = NUM_CAUSE;
   localparam int unsigned CTRL_W  = 2 * KEY_W + 2;

   if (KEY_W < 3 || KEY_W > 8) begin : g_bad_key
      $error("KEY_W must be 3..8");
   end
   if (DATA_W <= WB_BIT || DATA_W < CTRL_W) begin : g_bad_data
      $error("DATA_W too narrow");
   end

   logic [KEY_W-1:0]     wd_key, ts_key;
   logic                 lockup_en, wdog3_glob;
   logic                 wd_masked, ts_masked;
   logic [NUM_CAUSE-1:0] set_vec, blk_vec, w1c_vec, flags;
   logic                 warm_boot, wr_ctrl, wr_stat;

   assign wr_ctrl = wr_en && (reg_sel_e'(addr) == SEL_CTRL);
   assign wr_stat = wr_en && (reg_sel_e'(addr) == SEL_STAT);
   assign w1c_vec = wr_stat ? wr_data[NUM_CAUSE-1:0] : '0;

   assign wd_masked = key_masks(8'(wd_key), 8'(MASK_KEY));
   assign ts_masked = key_masks(8'(ts_key), 8'(MASK_KEY));

   rcr_ctrl_regs #(
      .DATA_W(DATA_W), .KEY_W(KEY_W), .WD_RUN_KEY(WD_RUN_KEY), .TS_RUN_KEY(TS_RUN_KEY)
   ) ctrl_i (
      .clk(clk), .por_n(por_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
      .wd_key(wd_key), .ts_key(ts_key), .lockup_en(lockup_en), .wdog3_glob(wdog3_glob)
   );

   rcr_qualify #(.NCAUSE(NUM_CAUSE)) qual_i (
      .clk(clk), .por_n(por_n),
      .wdog_evt(wdog_evt), .tsense_evt(tsense_evt), .lockup_evt(lockup_evt),
      .swreq_evt(swreq_evt), .jtag_gen_evt(jtag_gen_evt), .jtag_sw_evt(jtag_sw_evt),
      .wdog3_evt(wdog3_evt), .wd_masked(wd_masked), .ts_masked(ts_masked),
      .lockup_en(lockup_en), .wdog3_glob(wdog3_glob),
      .set_vec(set_vec), .blk_vec(blk_vec),
      .glob_rst_req(glob_rst_req), .core_rst_req(core_rst_req)
   );

   rcr_cause_flags #(.NCAUSE(NUM_CAUSE)) flags_i (
      .clk(clk), .por_n(por_n), .set_vec(set_vec), .blk_vec(blk_vec), .w1c_vec(w1c_vec),
      .wb_wr(wr_stat), .wb_data(wr_data[WB_BIT]), .flags(flags), .warm_boot(warm_boot)
   );

   always_comb begin
      rd_data = '0;
      if (reg_sel_e'(addr) == SEL_STAT) begin
         rd_data[NUM_CAUSE-1:0] = flags;
         rd_data[WB_BIT]        = warm_boot;
      end else begin
         rd_data[CTRL_W-1:0] = {wdog3_glob, lockup_en, ts_key, wd_key};
      end
   end

   AST_WB_NO_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
      (wr_stat && wr_data[NUM_CAUSE-1:0] == '0)
      |=> ((flags & $past(flags)) == $past(flags))); // R10
   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!por_n)
      (wdog3_evt && !wdog3_glob && !wdog_evt && !tsense_evt && !lockup_evt && !swreq_evt
       && !jtag_gen_evt && !jtag_sw_evt) |=> (core_rst_req && !glob_rst_req)); // R9
endmodule

// File: tb/reset_cause_rec_tb_top.sv
module reset_cause_rec_tb_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic [6:0]  ev = '0;   // 0 wdog,1 tsense,2 lockup,3 sw,4 jgen,5 jsw,6 wdog3
   logic        wr_en = 1'b0;
   logic        addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        glob_rst_req, core_rst_req;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   reset_cause_rec dut_i (
      .clk(clk), .por_n(por_n),
      .wdog_evt(ev[0]), .tsense_evt(ev[1]), .lockup_evt(ev[2]), .swreq_evt(ev[3]),
      .jtag_gen_evt(ev[4]), .jtag_sw_evt(ev[5]), .wdog3_evt(ev[6]),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .glob_rst_req(glob_rst_req), .core_rst_req(core_rst_req)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic do_por();
      @(negedge clk); por_n = 1'b0; ev = '0; wr_en = 1'b0;
      @(negedge clk); @(negedge clk); por_n = 1'b1;
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      addr = a; #1; d = rd_data;
   endtask

   // Drive one source for one cycle; on return the capturing edge has passed.
   task automatic pulse(input int idx);
      @(negedge clk); ev[idx] = 1'b1;
      @(negedge clk); ev[idx] = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      @(negedge clk); por_n = 1'b0; #1;
      rd(1'b1, d); chk("R1", "status during por", d, 32'h001);
      do_por();
      rd(1'b1, d); chk("R1", "status after por", d, 32'h001);
      rd(1'b0, d); chk("R1", "ctrl default", d, 32'h02A);
      chk("R1", "glob idle", glob_rst_req, 0);
      chk("R1", "core idle", core_rst_req, 0);
   endtask

   task automatic t_each_src();
      logic [31:0] d;
      int srcs [4] = '{3, 4, 5, 0};
      foreach (srcs[k]) begin
         do_por(); wr(1'b1, 32'h1);
         pulse(srcs[k]);
         chk("R2", "glob after event", glob_rst_req, 1);
         rd(1'b1, d); chk("R2", "own flag", d, 32'h1 << (srcs[k] + 1));
         @(negedge clk);
         chk("R2", "glob drops", glob_rst_req, 0);
      end
      do_por(); wr(1'b1, 32'h1);
      pulse(1);
      chk("R5", "sensor active by default", glob_rst_req, 1);
      rd(1'b1, d); chk("R2", "sensor flag bit2", d, 32'h004);
   endtask

   task automatic t_wdog_mask();
      logic [31:0] d;
      do_por(); wr(1'b0, 32'h025); wr(1'b1, 32'h1);
      pulse(0);
      chk("R3", "masked wdog no glob", glob_rst_req, 0);
      rd(1'b1, d); chk("R4", "masked wdog flag set", d, 32'h002);
      wr(1'b1, 32'h2);
      rd(1'b1, d); chk("R4", "w1c ignored while masked", d, 32'h002);
      wr(1'b0, 32'h02A); wr(1'b1, 32'h2);
      rd(1'b1, d); chk("R4", "w1c ignored after unmask", d, 32'h002);
      do_por();
      rd(1'b1, d); chk("R4", "por clears sticky", d, 32'h001);
      pulse(0);
      chk("R3", "key 0xA wdog active", glob_rst_req, 1);
      wr(1'b1, 32'h2);
      rd(1'b1, d); chk("R3", "unlocked flag clears", d, 32'h001);
   endtask

   task automatic t_ts();
      logic [31:0] d;
      do_por(); wr(1'b0, 32'h05A); wr(1'b1, 32'h1);
      pulse(1);
      chk("R5", "masked sensor no glob", glob_rst_req, 0);
      rd(1'b1, d); chk("R5", "masked sensor no flag", d, 32'h000);
      wr(1'b0, 32'h02A);
      @(negedge clk); ev[1] = 1'b1;
      wr(1'b1, 32'h4);
      rd(1'b1, d); chk("R6", "clear blocked while high", d, 32'h004);
      @(negedge clk); ev[1] = 1'b0;
      wr(1'b1, 32'h4);
      rd(1'b1, d); chk("R6", "clear after low", d, 32'h000);
   endtask

   task automatic t_failsafe();
      do_por(); wr(1'b0, 32'h0F0);
      pulse(0);
      chk("R7", "wdog key 0x0 active", glob_rst_req, 1);
      pulse(1);
      chk("R7", "sensor key 0xF active", glob_rst_req, 1);
      wr(1'b0, 32'h04D);
      pulse(0);
      chk("R7", "wdog key 0xD active", glob_rst_req, 1);
   endtask

   task automatic t_lockup();
      logic [31:0] d;
      do_por(); wr(1'b1, 32'h1);
      pulse(2);
      chk("R8", "lockup disabled no glob", glob_rst_req, 0);
      rd(1'b1, d); chk("R8", "lockup disabled no flag", d, 32'h000);
      wr(1'b0, 32'h12A);
      pulse(2);
      chk("R8", "lockup enabled glob", glob_rst_req, 1);
      rd(1'b1, d); chk("R8", "lockup flag bit3", d, 32'h008);
   endtask

   task automatic t_wdog3();
      logic [31:0] d;
      do_por(); wr(1'b1, 32'h1);
      pulse(6);
      chk("R9", "opt0 core req", core_rst_req, 1);
      chk("R9", "opt0 no glob", glob_rst_req, 0);
      rd(1'b1, d); chk("R9", "wdog3 flag bit7", d, 32'h080);
      wr(1'b0, 32'h22A);
      pulse(6);
      chk("R9", "opt1 glob req", glob_rst_req, 1);
      chk("R9", "opt1 no core", core_rst_req, 0);
   endtask

   task automatic t_warmboot();
      logic [31:0] d;
      do_por();
      pulse(3); pulse(4);
      wr(1'b1, 32'h100);
      rd(1'b1, d); chk("R10", "warm set keeps causes", d, 32'h131);
      wr(1'b1, 32'h110);
      rd(1'b1, d); chk("R10", "w1c one cause", d, 32'h121);
      wr(1'b1, 32'h000);
      rd(1'b1, d); chk("R10", "warm cleared causes kept", d, 32'h021);
   endtask

   initial begin
      t_reset();
      t_each_src();
      t_wdog_mask();
      t_ts();
      t_failsafe();
      t_lockup();
      t_wdog3();
      t_warmboot();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule